// File: doc/BRIEF.md
# Byte-Wide Parallel NOR Program and Read Controller

This block sits between a simple request port and an asynchronous parallel NOR flash wired for 8-bit access with a 24-bit byte address. It carries out one of two operations per request. A read fetches one byte from the array. A program writes the program-setup command and then the data byte to the target address. It then re-reads the device status byte until the ready flag is set, and finally writes the read-array command so that later reads return array contents.

Every bus cycle has a fixed length, counted in clock cycles that are derived from the clock period and nanosecond parameters. With the default 20 ns clock, read strobes are held for 5 cycles (100 ns) before the data is captured. The write strobe is held low for 6 cycles (120 ns). At least one cycle with all strobes released separates consecutive bus cycles. The flash data byte is split into an input, an output and an output enable, which the pad ring joins into one bidirectional byte. The upper half of a 16-bit data bus is not part of the interface and is never driven.

Top module: `nor_byte_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, fl_ce_n, fl_oe_n and fl_we_n are 1, fl_dq_oe is 0 and done is 0.
- R2: A request with op = 0 (read) runs one bus cycle. During that cycle fl_ce_n and fl_oe_n are 0, fl_we_n is 1 and fl_dq_oe is 0, for exactly 5 clock cycles at the default timing. The byte present at the end of the fifth cycle appears on rdata when done is 1.
- R3: Every write bus cycle holds fl_ce_n and fl_we_n at 0, fl_oe_n at 1 and fl_dq_oe at 1 for exactly 6 clock cycles at the default timing. fl_dq_out carries the byte being written.
- R4: A request with op = 1 (program) first writes the byte 0x40 and then the wdata byte, both at the requested address.
- R5: After the data byte, the status byte is read once per poll at the requested address until its bit 7 is 1. The number of status reads is the number of busy (bit 7 = 0) replies plus one.
- R6: Once a status byte with bit 7 = 1 is read, the byte 0xFF is written as the last bus cycle of the program operation, and done follows it.
- R7: At the end of a program, status holds the last status byte read, including any set bits in positions 6..0 (0x80 means success).
- R8: Consecutive bus cycles are separated by at least one clock with fl_ce_n, fl_oe_n and fl_we_n all 1. fl_addr stays stable and equal to the requested address throughout each cycle.
- R9: done is a single-cycle pulse per accepted request. A request raised while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (default period 20 ns) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start an operation (accepted only when idle) |
| op | input | 1 | 0 = read byte, 1 = program byte |
| addr | input | 24 | Byte address |
| wdata | input | 8 | Byte to program |
| rdata | output | 8 | Byte returned by the last read |
| status | output | 8 | Last status byte seen by a program |
| done | output | 1 | One-cycle completion pulse |
| fl_addr | output | 24 | Flash address |
| fl_dq_out | output | 8 | Data byte driven to the flash |
| fl_dq_oe | output | 1 | Enables the data byte driver |
| fl_dq_in | input | 8 | Data byte from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The flash model in the bench returns a junk byte until the output enable has been low for five full cycles. It also rejects any write pulse shorter than six cycles. A controller that samples early therefore returns the wrong byte, and one that releases the write strobe early is counted as a timing failure. Busy counts of zero, three and ten show whether polling stops one poll too early or too late. A ready status that also carries an error bit checks that the final byte, and not a fixed 0x80, is reported. A second request raised in the middle of a long program would, on a faulty design, move the address or produce an extra done pulse.

// File: rtl/nor_ctrl_pkg.sv
package nor_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACT,
    PH_GAP
  } bus_phase_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_READ,
    SQ_CMD,
    SQ_DATA,
    SQ_POLL,
    SQ_RESTORE,
    SQ_DONE
  } seq_state_e;

  localparam logic       OP_READ        = 1'b0;
  localparam logic       OP_PROG        = 1'b1;
  localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam int         READY_BIT      = 7;

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int RD_CYC  = 5,
  parameter int WR_CYC  = 6,
  parameter int GAP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              idle,
  output logic              cyc_done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n
);

  localparam int GAP_EFF = (GAP_CYC < 1) ? 1 : GAP_CYC;
  localparam int MAX_A   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAX_CYC = (MAX_A > GAP_EFF) ? MAX_A : GAP_EFF;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  bus_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              load_en;
  logic              smp_en;
  logic              ce_n_d, oe_n_d, we_n_d, dq_oe_d;
  logic              wr_eff;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    smp_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          phase_d = PH_ACT;
          cnt_d   = wr ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      PH_ACT: begin
        if (cnt_q == '0) begin
          smp_en  = !wr_q;
          phase_d = PH_GAP;
          cnt_d   = CNT_W'(GAP_EFF - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_GAP: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign wr_eff  = load_en ? wr : wr_q;
  assign ce_n_d  = (phase_d != PH_ACT);
  assign oe_n_d  = !((phase_d == PH_ACT) && !wr_eff);
  assign we_n_d  = !((phase_d == PH_ACT) && wr_eff);
  assign dq_oe_d = (phase_d == PH_ACT) && wr_eff;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ce_n    <= ce_n_d;
      oe_n    <= oe_n_d;
      we_n    <= we_n_d;
      dq_oe   <= dq_oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      wr_q    <= wr;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (smp_en) begin
      rdata_q <= dq_in;
    end
  end

  assign idle     = (phase_q == PH_IDLE);
  assign cyc_done = (phase_q == PH_GAP) && (cnt_q == '0);
  assign rdata    = rdata_q;
  assign fl_addr  = addr_q;
  assign dq_out   = wdata_q;

endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_ctrl_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bus_idle,
  input  logic              cyc_done,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_start,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] status,
  output logic              done
);

  seq_state_e        state_q, state_d;
  logic              issued_q, issued_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] status_q;
  logic              req_en;
  logic              rdata_en;
  logic              status_en;
  logic              want_cycle;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    issued_d   = issued_q;
    req_en     = 1'b0;
    rdata_en   = 1'b0;
    status_en  = 1'b0;
    want_cycle = 1'b0;
    bus_wr     = 1'b0;
    bus_wdata  = '0;
    unique case (state_q)
      SQ_IDLE: begin
        if (req) begin
          req_en   = 1'b1;
          issued_d = 1'b0;
          state_d  = (op == OP_PROG) ? SQ_CMD : SQ_READ;
        end
      end
      SQ_READ: begin
        want_cycle = 1'b1;
        if (cyc_done) begin
          rdata_en = 1'b1;
          issued_d = 1'b0;
          state_d  = SQ_DONE;
        end
      end
      SQ_CMD: begin
        want_cycle = 1'b1;
        bus_wr     = 1'b1;
        bus_wdata  = DATA_W'(CMD_PROG_SETUP);
        if (cyc_done) begin
          issued_d = 1'b0;
          state_d  = SQ_DATA;
        end
      end
      SQ_DATA: begin
        want_cycle = 1'b1;
        bus_wr     = 1'b1;
        bus_wdata  = wdata_q;
        if (cyc_done) begin
          issued_d = 1'b0;
          state_d  = SQ_POLL;
        end
      end
      SQ_POLL: begin
        want_cycle = 1'b1;
        if (cyc_done) begin
          status_en = 1'b1;
          issued_d  = 1'b0;
          if (bus_rdata[READY_BIT]) state_d = SQ_RESTORE;
        end
      end
      SQ_RESTORE: begin
        want_cycle = 1'b1;
        bus_wr     = 1'b1;
        bus_wdata  = DATA_W'(CMD_READ_ARRAY);
        if (cyc_done) begin
          issued_d = 1'b0;
          state_d  = SQ_DONE;
        end
      end
      SQ_DONE: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
    bus_start = want_cycle && !issued_q && bus_idle;
    if (bus_start) issued_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_en) begin
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= bus_rdata;
    end
  end

  assign bus_addr = addr_q;
  assign rdata    = rdata_q;
  assign status   = status_q;
  assign done     = (state_q == SQ_DONE);

endmodule

// File: rtl/nor_byte_ctrl.sv
module nor_byte_ctrl #(
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 20,
  parameter int RD_ACCESS_NS = 100,
  parameter int WE_PULSE_NS  = 120,
  parameter int IDLE_NS      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] status,
  output logic              done,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam int RD_CYC  = (RD_ACCESS_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_CYC  = (WE_PULSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int GAP_CYC = (IDLE_NS + CLK_NS - 1) / CLK_NS;

  logic              bus_start;
  logic              bus_wr;
  logic              bus_idle;
  logic              cyc_done;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;

  nor_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .op       (op),
    .addr     (addr),
    .wdata    (wdata),
    .bus_idle (bus_idle),
    .cyc_done (cyc_done),
    .bus_rdata(bus_rdata),
    .bus_start(bus_start),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rdata    (rdata),
    .status   (status),
    .done     (done)
  );

  nor_bus_cycle #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .GAP_CYC(GAP_CYC)
  ) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (bus_start),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .dq_in   (fl_dq_in),
    .idle    (bus_idle),
    .cyc_done(cyc_done),
    .rdata   (bus_rdata),
    .fl_addr (fl_addr),
    .dq_out  (fl_dq_out),
    .dq_oe   (fl_dq_oe),
    .ce_n    (fl_ce_n),
    .oe_n    (fl_oe_n),
    .we_n    (fl_we_n)
  );

endmodule

// File: rtl/nor_byte_ctrl_chk.sv
module nor_byte_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              fl_dq_oe,
  input logic              fl_ce_n,
  input logic              fl_oe_n,
  input logic              fl_we_n
);

  // R2 / R3: no read or write strobe without chip enable
  assert_strobe_needs_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ce_n |-> (fl_oe_n && fl_we_n));

  // R3: read and write strobes never together
  assert_no_oe_we_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_oe_n && !fl_we_n));

  // R3: data driver only during a write strobe
  assert_drive_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_dq_oe |-> (!fl_we_n && fl_oe_n));

  // R2: data driver released while the flash drives
  assert_no_contention_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

  // R8: at least one cycle idle between bus cycles
  assert_idle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_ce_n) |=> fl_ce_n);

  // R8: address stable while selected
  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && !$past(fl_ce_n)) |-> $stable(fl_addr));

  // R9: done lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done never coincides with an active bus cycle
  assert_done_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fl_ce_n);

endmodule

bind nor_byte_ctrl nor_byte_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (done),
  .fl_addr (fl_addr),
  .fl_dq_oe(fl_dq_oe),
  .fl_ce_n (fl_ce_n),
  .fl_oe_n (fl_oe_n),
  .fl_we_n (fl_we_n)
);

// File: tb/nor_byte_ctrl_bench.sv
module nor_byte_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        op;
  logic [23:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [7:0]  status;
  logic        done;
  logic [23:0] fl_addr;
  logic [7:0]  fl_dq_out;
  logic        fl_dq_oe;
  logic [7:0]  fl_dq_in;
  logic        fl_ce_n;
  logic        fl_oe_n;
  logic        fl_we_n;

  nor_byte_ctrl u_nor_byte_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .rdata(rdata), .status(status), .done(done), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0]  mem [16];
  logic        arr_mode;
  logic        prog_pend;
  int          busy_left;
  int          polls_cfg;
  logic [7:0]  err_bits;
  logic [23:0] exp_addr;
  int oe_lo, we_lo;
  int rd_cnt, wr_cnt, addr_err, timing_err, done_cnt;
  logic [7:0] wlog [4];

  always_comb begin
    if (!fl_oe_n && oe_lo >= 5) begin
      if (arr_mode) fl_dq_in = mem[fl_addr[3:0]];
      else if (busy_left > 0) fl_dq_in = {1'b0, err_bits[6:0]};
      else fl_dq_in = {1'b1, err_bits[6:0]};
    end else begin
      fl_dq_in = 8'h5A;
    end
  end

  always @(negedge clk) begin
    oe_lo <= fl_oe_n ? 0 : oe_lo + 1;
    we_lo <= fl_we_n ? 0 : we_lo + 1;
    if (!fl_ce_n && fl_addr !== exp_addr) addr_err++;
    if (done) done_cnt++;
  end

  always @(posedge fl_oe_n) begin
    rd_cnt++;
    if (!arr_mode && busy_left > 0) busy_left--;
  end

  always @(posedge fl_we_n) begin
    if (we_lo != 6) timing_err++;
    if (wr_cnt < 4) wlog[wr_cnt] = fl_dq_out;
    wr_cnt++;
    if (prog_pend) begin
      mem[fl_addr[3:0]] = mem[fl_addr[3:0]] & fl_dq_out;
      prog_pend = 1'b0;
      busy_left = polls_cfg;
      arr_mode  = 1'b0;
    end else if (fl_dq_out == 8'h40) begin
      prog_pend = 1'b1;
      arr_mode  = 1'b0;
    end else if (fl_dq_out == 8'hFF) begin
      arr_mode = 1'b1;
    end
  end

  // ---------------- vectors: op, addr, wdata, busy polls, error bits, expected ----------------
  localparam int NVEC = 8;
  localparam logic [56:0] VEC [NVEC] = '{
    {1'b0, 24'h000003, 8'h00, 8'd0,  8'h00, 8'hFF},
    {1'b1, 24'hABC003, 8'hA5, 8'd3,  8'h00, 8'h80},
    {1'b0, 24'hABC003, 8'h00, 8'd0,  8'h00, 8'hA5},
    {1'b1, 24'h000003, 8'h0F, 8'd0,  8'h00, 8'h80},
    {1'b0, 24'h000003, 8'h00, 8'd0,  8'h00, 8'h05},
    {1'b1, 24'hFFFFFF, 8'h3C, 8'd10, 8'h10, 8'h90},
    {1'b0, 24'hFFFFFF, 8'h00, 8'd0,  8'h00, 8'h3C},
    {1'b0, 24'h00000A, 8'h00, 8'd0,  8'h00, 8'hFF}
  };

  task automatic clear_counts();
    rd_cnt = 0; wr_cnt = 0; addr_err = 0; timing_err = 0; done_cnt = 0;
    for (int i = 0; i < 4; i++) wlog[i] = 8'h00;
  endtask

  task automatic launch(input logic o, input logic [23:0] a, input logic [7:0] d,
                        input int polls, input logic [7:0] eb);
    @(negedge clk);
    exp_addr  = a;
    polls_cfg = polls;
    err_bits  = eb;
    clear_counts();
    req = 1'b1; op = o; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    arr_mode = 1'b1; prog_pend = 1'b0; busy_left = 0; polls_cfg = 0;
    err_bits = 8'h00; exp_addr = 24'h0; oe_lo = 0; we_lo = 0;
    clear_counts();
    req = 1'b0; op = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ce_n in reset", {31'd0, fl_ce_n}, 32'd1);
    chk("R1 oe/we in reset", {30'd0, fl_oe_n, fl_we_n}, 32'd3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle strobes", {29'd0, fl_ce_n, fl_oe_n, fl_we_n}, 32'd7);
    chk("R1 idle dq_oe/done", {30'd0, fl_dq_oe, done}, 32'd0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic        vo;
      logic [23:0] va;
      logic [7:0]  vd, vp, ve, vx;
      bit ok;
      {vo, va, vd, vp, ve, vx} = VEC[v];
      launch(vo, va, vd, int'(vp), ve);
      wait_done(ok);
      chk("R9 done seen", {31'd0, ok}, 32'd1);
      if (vo == 1'b0) begin
        chk("R2 read data", {24'd0, rdata}, {24'd0, vx});
        chk("R2 one read cycle", rd_cnt, 1);
      end else begin
        chk("R7 final status", {24'd0, status}, {24'd0, vx});
        chk("R5 status reads", rd_cnt, int'(vp) + 1);
        chk("R4 setup cmd", {24'd0, wlog[0]}, 32'h40);
        chk("R4 data byte", {24'd0, wlog[1]}, {24'd0, vd});
        chk("R6 read-array cmd", {24'd0, wlog[2]}, 32'hFF);
        chk("R6 write count", wr_cnt, 3);
        chk("R3 we pulse width", timing_err, 0);
      end
      chk("R8 address held", addr_err, 0);
      @(negedge clk);
      chk("R9 done one cycle", {31'd0, done}, 32'd0);
      chk("R9 done count", done_cnt, 1);
    end

    // directed: request during a program is ignored
    begin
      bit ok;
      launch(1'b1, 24'h000005, 8'h77, 20, 8'h00);
      repeat (30) @(negedge clk);
      req = 1'b1; op = 1'b0; addr = 24'h00000C; wdata = 8'h00;
      @(negedge clk);
      req = 1'b0;
      wait_done(ok);
      chk("R9 done after overlap", {31'd0, ok}, 32'd1);
      chk("R9 ignored req address", addr_err, 0);
      chk("R9 ignored req polls", rd_cnt, 21);
      chk("R7 status after overlap", {24'd0, status}, 32'h80);
      repeat (40) @(negedge clk);
      chk("R9 single done", done_cnt, 1);
      chk("R1 back to idle", {29'd0, fl_ce_n, fl_oe_n, fl_we_n}, 32'd7);
    end

    // directed: read back the overlapped program and check strobe idle state
    begin
      bit ok;
      launch(1'b0, 24'h000005, 8'h00, 0, 8'h00);
      wait_done(ok);
      chk("R2 read after program", {24'd0, rdata}, 32'h77);
      chk("R3 no writes on read", wr_cnt, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule